// File: doc/BRIEF.md
# Transmit Gap Code Inserter

This block sits on the transmit side of a four-lane, byte-wide 10-Gbps Ethernet extender path. Each clock it takes one column of four bytes, each with a control flag. Lane `i` occupies bits `8i+7:8i` of the data bus and bit `i` of the control bus. Start, data and terminate columns go through unchanged, and one cycle later they appear at the output. Idle bytes in the inter-packet gap are rewritten into the codes a far-end receiver needs.

- **Inside the terminate column:** idle lanes become K28.5.
- **Whole idle columns after the terminate column:** each becomes a column in which every lane carries the same code: K28.3 (lane alignment, "A"), K28.5 (synchronisation, "K") or K28.0 (clock compensation, "R").
- **How the next code is chosen:** a small state machine picks the code. A countdown spaces the A columns, so the receiver can re-align its lanes at regular points. A 7-bit pseudo-random shift register sets the length of that countdown and chooses between K and R.

The block's outputs feed an 8b/10b encoder. Input codes: idle is 0x07, start is 0xFB and terminate is 0xFD, each with its control flag set. Output codes with the control flag set: A is 0x7C, K is 0xBC and R is 0x1C.

Top module: `xlg_gap_fill`

## Requirements
- R1: While reset is held, the output is a K column: all lanes 0xBC with all control flags 1. From reset until the first start column has been accepted, every other input column also produces a K column.
- R2: A column that is neither start, terminate nor all-idle comes out exactly one cycle later unchanged in data and control. This includes a pure data column, where all control flags are 0.
- R3: In a terminate column (any lane with control 1 and byte 0xFD), each idle lane (control 1, byte 0x07) is output as 0xBC with control 1. All other lanes of that column are unchanged.
- R4: The first all-idle column directly after a terminate column is output as 0x7C on all four lanes.
- R5: After the first start, every all-idle input column becomes a column whose four lanes carry one identical code, 0x7C, 0xBC or 0x1C, with all control flags 1.
- R6: A 7-bit shift register is seeded to 0x5A by reset. Each clock it shifts left and inserts bit 6 XOR bit 5 at bit 0. An all-idle column that is not made an A column becomes K when bit 6 of the current value is 1, and R when it is 0.
- R7: Each time an A column is chosen, a countdown is loaded with L-1, where L = 16 + bits 3:0 of the current shift-register value. The countdown drops by one per column. When an all-idle column arrives with the countdown at zero, that column is an A column. In an uninterrupted run of idle columns, consecutive A columns are therefore exactly L columns apart, with L from 16 to 31.
- R8: The countdown keeps running through non-idle columns. If it reaches zero there, the next all-idle column is sent as an A column.
- R9: A start column (lane 0 control 1, byte 0xFB) is passed unchanged from every state, including a pending gap. It takes priority over a terminate in the same column.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 32 | Input column, lane i in bits 8i+7:8i |
| in_ctrl | input | 4 | Input control flag per lane |
| out_data | output | 32 | Output column, one cycle after input |
| out_ctrl | output | 4 | Output control flag per lane |

## Verification
The bench builds the block with its default parameters: four lanes, a minimum A spacing of 16 with a 4-bit random span, and the 7-bit register seeded to 0x5A. These values keep every spacing between 16 and 31 columns. Gaps of 70 and 200 columns therefore show several A columns in a row, so the spacing check sees many countdown values. A run of non-idle, non-packet columns longer than the widest spacing forces the countdown to expire outside a gap. Packets whose terminate falls on each of the four lanes exercise the partial terminate column.

// File: rtl/xlg_pkg.sv
package xlg_pkg;

    localparam int unsigned LANE_W = 8;

    // input column codes (control flag set)
    localparam logic [LANE_W-1:0] XG_IDLE  = 8'h07;
    localparam logic [LANE_W-1:0] XG_START = 8'hFB;
    localparam logic [LANE_W-1:0] XG_TERM  = 8'hFD;

    // replacement codes (control flag set)
    localparam logic [LANE_W-1:0] CODE_ALIGN = 8'h7C;  // K28.3
    localparam logic [LANE_W-1:0] CODE_SYNC  = 8'hBC;  // K28.5
    localparam logic [LANE_W-1:0] CODE_SKIP  = 8'h1C;  // K28.0

    typedef enum logic [1:0] {
        ST_BOOT,
        ST_PKT,
        ST_TERM,
        ST_GAP
    } gap_st_e;

    typedef enum logic [2:0] {
        ACT_PASS,
        ACT_TERM,
        ACT_ALIGN,
        ACT_SYNC,
        ACT_SKIP
    } col_act_e;

endpackage

// File: rtl/xlg_col_class.sv
module xlg_col_class
    import xlg_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic [LANES*LANE_W-1:0] col_data,
    input  logic [LANES-1:0]        col_ctrl,
    output logic [LANES-1:0]        lane_idle,
    output logic                    col_idle,
    output logic                    col_start,
    output logic                    col_term
);

    logic [LANES-1:0] lane_term;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_idle[g] = col_ctrl[g] && (col_data[g*LANE_W +: LANE_W] == XG_IDLE);
        assign lane_term[g] = col_ctrl[g] && (col_data[g*LANE_W +: LANE_W] == XG_TERM);
    end

    assign col_idle  = &lane_idle;
    assign col_term  = |lane_term;
    // a packet may only open on lane 0
    assign col_start = col_ctrl[0] && (col_data[LANE_W-1:0] == XG_START);

endmodule

// File: rtl/xlg_prbs.sv
module xlg_prbs #(
    parameter int unsigned   W      = 7,
    parameter int unsigned   TAP_A  = 6,
    parameter int unsigned   TAP_B  = 5,
    parameter int unsigned   SPAN_W = 4,
    parameter logic [W-1:0]  SEED   = 7'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              rand_pick,
    output logic [SPAN_W-1:0] rand_span
);

    logic [W-1:0] state_d, state_q;

    always_comb begin
        state_d = {state_q[W-2:0], state_q[TAP_A] ^ state_q[TAP_B]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end

    assign rand_pick = state_q[W-1];
    assign rand_span = state_q[SPAN_W-1:0];

endmodule

// File: rtl/xlg_gap_ctrl.sv
module xlg_gap_ctrl
    import xlg_pkg::*;
#(
    parameter int unsigned A_MIN  = 16,
    parameter int unsigned SPAN_W = 4,
    parameter int unsigned CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              col_idle,
    input  logic              col_start,
    input  logic              col_term,
    input  logic              rand_pick,
    input  logic [SPAN_W-1:0] rand_span,
    output col_act_e          act
);

    localparam logic [CNT_W-1:0] CNT_BASE = CNT_W'(A_MIN - 1);

    typedef struct packed {
        gap_st_e          st;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t             r_d, r_q;
    logic [CNT_W-1:0] reload;

    always_comb begin
        reload = CNT_BASE + CNT_W'(rand_span);
        r_d    = r_q;
        act    = ACT_PASS;

        if (r_q.st == ST_BOOT) begin
            if (col_start) r_d.st = ST_PKT;
            else           act    = ACT_SYNC;
        end else if (col_start) begin
            r_d.st = ST_PKT;
        end else if (col_term) begin
            act    = ACT_TERM;
            r_d.st = ST_TERM;
        end else if (col_idle) begin
            r_d.st = ST_GAP;
            if (r_q.st == ST_TERM || r_q.cnt == '0) act = ACT_ALIGN;
            else if (rand_pick)                      act = ACT_SYNC;
            else                                     act = ACT_SKIP;
        end else begin
            r_d.st = ST_PKT;
        end

        if (act == ACT_ALIGN)                              r_d.cnt = reload;
        else if (r_q.st != ST_BOOT && r_q.cnt != '0)       r_d.cnt = r_q.cnt - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_BOOT;
            r_q.cnt <= CNT_BASE;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/xlg_gap_fill.sv
module xlg_gap_fill
    import xlg_pkg::*;
#(
    parameter int unsigned     LANES      = 4,
    parameter int unsigned     A_MIN      = 16,
    parameter int unsigned     SPAN_W     = 4,
    parameter int unsigned     PRBS_W     = 7,
    parameter int unsigned     PRBS_TAP_A = 6,
    parameter int unsigned     PRBS_TAP_B = 5,
    parameter logic [PRBS_W-1:0] PRBS_SEED = 7'h5A
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES*LANE_W-1:0] in_data,
    input  logic [LANES-1:0]        in_ctrl,
    output logic [LANES*LANE_W-1:0] out_data,
    output logic [LANES-1:0]        out_ctrl
);

    localparam int unsigned DW    = LANES * LANE_W;
    localparam int unsigned CNT_W = $clog2(A_MIN + (1 << SPAN_W));

    typedef struct packed {
        logic [DW-1:0]    data;
        logic [LANES-1:0] ctrl;
    } col_t;

    col_t              o_d, o_q;
    logic [LANES-1:0]  lane_idle;
    logic              col_idle, col_start, col_term;
    logic              rand_pick;
    logic [SPAN_W-1:0] rand_span;
    col_act_e          act;

    xlg_col_class #(.LANES(LANES)) u_class (
        .col_data  (in_data),
        .col_ctrl  (in_ctrl),
        .lane_idle (lane_idle),
        .col_idle  (col_idle),
        .col_start (col_start),
        .col_term  (col_term)
    );

    xlg_prbs #(
        .W      (PRBS_W),
        .TAP_A  (PRBS_TAP_A),
        .TAP_B  (PRBS_TAP_B),
        .SPAN_W (SPAN_W),
        .SEED   (PRBS_SEED)
    ) u_prbs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rand_pick (rand_pick),
        .rand_span (rand_span)
    );

    xlg_gap_ctrl #(
        .A_MIN  (A_MIN),
        .SPAN_W (SPAN_W),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .col_idle  (col_idle),
        .col_start (col_start),
        .col_term  (col_term),
        .rand_pick (rand_pick),
        .rand_span (rand_span),
        .act       (act)
    );

    always_comb begin
        o_d.data = in_data;
        o_d.ctrl = in_ctrl;
        unique case (act)
            ACT_TERM: begin
                for (int i = 0; i < LANES; i++) begin
                    if (lane_idle[i]) o_d.data[i*LANE_W +: LANE_W] = CODE_SYNC;
                end
            end
            ACT_ALIGN: begin
                o_d.data = {LANES{CODE_ALIGN}};
                o_d.ctrl = '1;
            end
            ACT_SYNC: begin
                o_d.data = {LANES{CODE_SYNC}};
                o_d.ctrl = '1;
            end
            ACT_SKIP: begin
                o_d.data = {LANES{CODE_SKIP}};
                o_d.ctrl = '1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q.data <= {LANES{CODE_SYNC}};
            o_q.ctrl <= '1;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_data = o_q.data;
    assign out_ctrl = o_q.ctrl;

endmodule

// File: rtl/xlg_gap_fill_chk.sv
module xlg_gap_fill_chk
    import xlg_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [LANES*LANE_W-1:0] in_data,
    input logic [LANES-1:0]        in_ctrl,
    input logic [LANES*LANE_W-1:0] out_data,
    input logic [LANES-1:0]        out_ctrl
);

    logic [LANES-1:0] li, lt, lo;
    logic c_idle, c_start, c_term, uni, okcode;
    logic started_q, live_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign li[g] = in_ctrl[g]  && (in_data[g*LANE_W +: LANE_W]  == XG_IDLE);
        assign lt[g] = in_ctrl[g]  && (in_data[g*LANE_W +: LANE_W]  == XG_TERM);
        assign lo[g] = out_ctrl[g] && (out_data[g*LANE_W +: LANE_W] == XG_IDLE);
    end

    assign c_idle  = &li;
    assign c_term  = |lt;
    assign c_start = in_ctrl[0] && (in_data[LANE_W-1:0] == XG_START);
    assign uni     = (out_data == {LANES{out_data[LANE_W-1:0]}}) && (out_ctrl == '1);
    assign okcode  = (out_data[LANE_W-1:0] == CODE_ALIGN) || (out_data[LANE_W-1:0] == CODE_SYNC)
                  || (out_data[LANE_W-1:0] == CODE_SKIP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            live_q    <= 1'b0;
        end else begin
            live_q <= 1'b1;
            if (c_start) started_q <= 1'b1;
        end
    end

    p_boot_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!started_q && !c_start) |-> (uni && out_data[LANE_W-1:0] == CODE_SYNC));

    p_data_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(started_q && in_ctrl == '0) |-> (out_data == $past(in_data) && out_ctrl == '0));

    p_term_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(started_q && c_term && !c_start) |-> (out_ctrl == $past(in_ctrl) && lo == '0));

    p_first_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(started_q && c_term && !c_start, 2) && $past(c_idle))
        |-> (uni && out_data[LANE_W-1:0] == CODE_ALIGN));

    p_gap_uniform_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(started_q && c_idle) |-> (uni && okcode));

    p_start_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(c_start)) |-> (out_data == $past(in_data) && out_ctrl == $past(in_ctrl)));

endmodule

bind xlg_gap_fill xlg_gap_fill_chk #(.LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_data  (in_data),
    .in_ctrl  (in_ctrl),
    .out_data (out_data),
    .out_ctrl (out_ctrl)
);

// File: tb/xlg_gap_fill_tb.sv
module xlg_gap_fill_tb;
    import xlg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_data = 32'h07070707;
    logic [3:0]  in_ctrl = 4'hF;
    logic [31:0] out_data;
    logic [3:0]  out_ctrl;

    always #4 clk = ~clk;  // 125 MHz

    xlg_gap_fill u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (in_data),
        .in_ctrl  (in_ctrl),
        .out_data (out_data),
        .out_ctrl (out_ctrl)
    );

    int n_chk = 0;
    int n_bad = 0;

    // behavioural reference state
    int          m_st;    // 0 boot, 1 packet, 2 just terminated, 3 gap
    int          m_cnt;
    int          m_lfsr;
    logic [31:0] e_data = 32'hBCBCBCBC;
    logic [3:0]  e_ctrl = 4'hF;
    string       e_tag  = "R1";
    int          a_since = 0;
    bit          a_run = 0;
    int          bseed = 1;

    task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit is_code(input logic [7:0] b);
        return b == CODE_ALIGN || b == CODE_SYNC || b == CODE_SKIP;
    endfunction

    task automatic model_step(input logic [31:0] d, input logic [3:0] c, input bit in_rst);
        bit idle_all, st_col, tm_col, a_pick;
        int old_st;
        if (in_rst) begin
            m_st = 0; m_cnt = 15; m_lfsr = 'h5A;
            e_data = 32'hBCBCBCBC; e_ctrl = 4'hF; e_tag = "R1";
            return;
        end
        idle_all = 1; tm_col = 0;
        for (int i = 0; i < 4; i++) begin
            if (!(c[i] && d[i*8 +: 8] == 8'h07)) idle_all = 0;
            if (c[i] && d[i*8 +: 8] == 8'hFD) tm_col = 1;
        end
        st_col = c[0] && d[7:0] == 8'hFB;
        old_st = m_st;
        a_pick = 0;
        e_data = d; e_ctrl = c;
        if (m_st == 0) begin
            if (st_col) begin m_st = 1; e_tag = "R9"; end
            else begin e_data = 32'hBCBCBCBC; e_ctrl = 4'hF; e_tag = "R1"; end
        end else if (st_col) begin
            m_st = 1; e_tag = "R9";
        end else if (tm_col) begin
            m_st = 2; e_tag = "R3";
            for (int i = 0; i < 4; i++)
                if (c[i] && d[i*8 +: 8] == 8'h07) e_data[i*8 +: 8] = 8'hBC;
        end else if (idle_all) begin
            e_ctrl = 4'hF;
            if (m_st == 2 || m_cnt == 0) begin
                a_pick = 1; e_data = 32'h7C7C7C7C;
                e_tag = (m_st == 2) ? "R4" : (m_st == 1) ? "R8" : "R7";
            end else if (((m_lfsr >> 6) & 1) == 1) begin
                e_data = 32'hBCBCBCBC; e_tag = "R6";
            end else begin
                e_data = 32'h1C1C1C1C; e_tag = "R6";
            end
            m_st = 3;
        end else begin
            m_st = 1; e_tag = "R2";
        end
        if (a_pick) m_cnt = 16 + (m_lfsr & 15) - 1;
        else if (old_st != 0 && m_cnt > 0) m_cnt = m_cnt - 1;
        m_lfsr = ((m_lfsr << 1) | (((m_lfsr >> 6) ^ (m_lfsr >> 5)) & 1)) & 127;
    endtask

    task automatic cycle(input logic [31:0] d, input logic [3:0] c, input logic rv);
        @(negedge clk);
        chk(out_data === e_data && out_ctrl === e_ctrl, e_tag, {out_ctrl, out_data}, {e_ctrl, e_data});
        if (e_ctrl == 4'hF && e_data == {4{e_data[7:0]}} && is_code(e_data[7:0]) && rst_n)
            chk(out_ctrl == 4'hF && out_data == {4{out_data[7:0]}}, "R5",
                {out_ctrl, out_data}, {e_ctrl, e_data});
        // A spacing inside uninterrupted replacement runs
        a_since++;
        if (out_ctrl == 4'hF && out_data == 32'h7C7C7C7C) begin
            if (a_run)
                chk(a_since >= 16 && a_since <= 31, "R7", 36'(a_since), 36'(16));
            a_run = 1; a_since = 0;
        end else if (!(out_ctrl == 4'hF && out_data == {4{out_data[7:0]}} && is_code(out_data[7:0]))) begin
            a_run = 0;
        end
        rst_n   = rv;
        in_data = d;
        in_ctrl = c;
        model_step(d, c, !rv);
    endtask

    task automatic idles(input int n);
        for (int k = 0; k < n; k++) cycle(32'h07070707, 4'hF, 1'b1);
    endtask

    function automatic logic [7:0] nb();
        bseed = (bseed * 37 + 11) & 255;
        return 8'(bseed);
    endfunction

    task automatic packet(input int ncols, input int tl);
        logic [31:0] d;
        logic [3:0]  c;
        d = {nb(), nb(), nb(), 8'hFB};
        cycle(d, 4'b0001, 1'b1);
        for (int k = 0; k < ncols; k++) cycle({nb(), nb(), nb(), nb()}, 4'h0, 1'b1);
        c = 4'h0;
        for (int i = 0; i < 4; i++) begin
            if (i < tl)       begin d[i*8 +: 8] = nb();   c[i] = 1'b0; end
            else if (i == tl) begin d[i*8 +: 8] = 8'hFD;  c[i] = 1'b1; end
            else              begin d[i*8 +: 8] = 8'h07;  c[i] = 1'b1; end
        end
        cycle(d, c, 1'b1);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        model_step(32'h07070707, 4'hF, 1'b1);
        // R1: reset state and boot K columns
        for (int k = 0; k < 3; k++) cycle(32'h07070707, 4'hF, 1'b0);
        idles(5);
        cycle(32'h11223344, 4'h0, 1'b1);           // R1: data before first start
        cycle(32'hFD070707, 4'hF, 1'b1);           // R1: terminate before first start
        // R2/R3/R4 on every terminate lane
        packet(6, 0); idles(3);
        packet(5, 1); idles(70);                   // R6/R7 long gap
        packet(9, 2); idles(20);
        packet(4, 3); idles(1);
        packet(3, 0);
        packet(2, 1);                              // R9 start right after terminate
        idles(10);
        packet(2, 2);                              // R9 start mid-gap
        idles(40);
        // R8: countdown expires over non-idle, non-packet columns
        for (int k = 0; k < 35; k++) cycle(32'h0000009C, 4'b0001, 1'b1);
        idles(30);
        // R9: start and terminate in one column
        cycle(32'h07FD00FB, 4'b1101, 1'b1);
        cycle(32'h01020304, 4'h0, 1'b1);
        cycle(32'h070707FD, 4'hF, 1'b1);
        idles(5);
        for (int j = 0; j < 40; j++) begin
            packet(j % 7 + 1, j % 4);
            idles(j % 9 + 1);
        end
        idles(200);
        cycle(32'h07070707, 4'hF, 1'b1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule